// File: doc/BRIEF.md
# Base Clock Divider with Configuration Lock

This block turns a base clock into two slower clocks: a CPU clock and a peripheral bus clock. The base clock is taken either from a PLL clock or from a main oscillator clock. Both sources arrive as single-cycle tick pulses in the fabric clock domain, and both outputs leave as single-cycle enable pulses. The whole design therefore runs on one clock and contains no gated or muxed clock nets. Each output has its own divider, and a two-bit field in the clock control register sets its ratio. A new ratio is adopted only when the current output period ends.

Software reaches the block through a small register bus: a write strobe with address and data, plus a read address with registered read data. A protect register guards the power-management register. The power-management register holds a lock bit. Once software sets the lock, the source select and both ratio fields are frozen until reset. Runaway code therefore cannot stop or retune the CPU clock.

Top module: `baseclk_divlock`

## Requirements
- R1: After reset the clock control register (address 0) reads 0: CPU code 00, bus code 00, source bit 0. The protect register (address 1) and the power-management register (address 2) also read 0. Both outputs divide the base ticks by 2.
- R2: The clock control register holds the CPU ratio code in bits [1:0]. Code 00 gives one cpu_en pulse per 2 base ticks, 01 per 3, 10 per 4 and 11 per 1.
- R3: The clock control register holds the bus ratio code in bits [3:2]. Code 00 gives one pbus_en pulse per 2 base ticks, 01 per 3, 10 per 4, and the reserved code 11 also per 4.
- R4: Bit 4 of the clock control register selects the base tick. A value of 0 selects pll_tick and 1 selects osc_tick.
- R5: An enable pulse appears only in the cycle after a base tick. A ratio write takes effect only after the output period that was running at the write completes, so no shortened period is produced.
- R6: A write to the power-management register is ignored while protect bit 0 of address 1 is 0.
- R7: The protect bit keeps its value until software writes address 1 again. It is not cleared by writes to the other addresses.
- R8: Once lock bit 0 of address 2 is 1, writes to the clock control register are ignored. Its readback and both output rates stay unchanged.
- R9: The lock bit cannot be cleared by a write, even with the protect bit set. Only reset clears it.
- R10: rd_data shows the register selected by rd_addr one cycle later, zero-extended. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_tick | input | 1 | Base tick from the PLL source |
| osc_tick | input | 1 | Base tick from the main oscillator source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Registered read data |
| cpu_en | output | 1 | CPU clock enable pulse |
| pbus_en | output | 1 | Peripheral bus clock enable pulse |

## Verification
The bench counts pulses over a window that is a multiple of every period. This catches a swapped or misdecoded ratio code, including the reserved bus code: a design that mapped it to /1 would show four times as many pulses. The bench switches the CPU ratio from /4 to /1 just after a pulse. It then checks that the next gap is still 4 cycles before the pulses become back-to-back. A design that reloaded the ratio at once would emit a truncated period here. The bench also checks the protection sequence. A lock write made without protect must not stick. A locked design must not accept a new ratio or a source switch. A clearing write to the lock bit must fail, and only reset may clear it.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    A_CCTL = 2'd0,
    A_PROT = 2'd1,
    A_PMG  = 2'd2
  } addr_e;

  typedef struct packed {
    logic       src;
    logic [1:0] pbus;
    logic [1:0] cpu;
  } cctl_t;

  localparam int CCTL_W = $bits(cctl_t);

  function automatic logic [CNT_W-1:0] cpu_ratio(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(2);
      2'b01:   return CNT_W'(3);
      2'b10:   return CNT_W'(4);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] pbus_ratio(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(2);
      2'b01:   return CNT_W'(3);
      default: return CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/bcd_regs.sv
module bcd_regs
  import bcd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output cctl_t             cctl_o
);
  cctl_t cctl_q;
  logic  prot_q;
  logic  lock_q;
  logic  [DATA_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cctl_q <= '0;
      prot_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_CCTL && !lock_q) cctl_q <= cctl_t'(wr_data[CCTL_W-1:0]);
      if (wr_addr == A_PROT)            prot_q <= wr_data[0];
      if (wr_addr == A_PMG && prot_q)   lock_q <= lock_q | wr_data[0];
    end
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      A_CCTL:  rd_d[CCTL_W-1:0] = cctl_q;
      A_PROT:  rd_d[0] = prot_q;
      A_PMG:   rd_d[0] = lock_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  assign cctl_o = cctl_q;

  AST_RST_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cctl_q == '0 && !prot_q && !lock_q)); // R1
  AST_PMG_GUARD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_PMG && !prot_q && !lock_q) |=> !lock_q); // R6
  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_addr == A_PROT)) |=> $stable(prot_q)); // R7
  AST_CCTL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(cctl_q)); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q); // R9
endmodule

// File: rtl/bcd_divider.sv
module bcd_divider #(
  parameter int CNT_W     = 3,
  parameter int RST_RATIO = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_q;
  logic             last;

  assign last = (cnt_q == cur_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cur_q <= CNT_W'(RST_RATIO);
      en_o  <= 1'b0;
    end else begin
      en_o <= 1'b0;
      if (tick_i) begin
        if (last) begin
          cnt_q <= '0;
          cur_q <= ratio_i;
          en_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    en_o |-> $past(tick_i)); // R5
  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < cur_q)); // R5
endmodule

// File: rtl/baseclk_divlock.sv
module baseclk_divlock
  import bcd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_tick,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cpu_en,
  output logic              pbus_en
);
  localparam int NUM_OUT = 2;

  cctl_t            cctl;
  logic             base_tick;
  logic [CNT_W-1:0] ratio [NUM_OUT];
  logic [NUM_OUT-1:0] en_vec;

  bcd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cctl_o(cctl)
  );

  assign base_tick = cctl.src ? osc_tick : pll_tick;
  assign ratio[0]  = cpu_ratio(cctl.cpu);
  assign ratio[1]  = pbus_ratio(cctl.pbus);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
    bcd_divider #(.CNT_W(CNT_W), .RST_RATIO(2)) u_div (
      .clk(clk), .rst(rst), .tick_i(base_tick), .ratio_i(ratio[g]), .en_o(en_vec[g])
    );
  end

  assign cpu_en  = en_vec[0];
  assign pbus_en = en_vec[1];

  AST_SRC_OSC_ONLY: assert property (@(posedge clk) disable iff (rst)
    ($past(cctl.src) && $stable(cctl.src) && !$past(osc_tick)) |-> !(cpu_en || pbus_en)); // R4
endmodule

// File: tb/tb_baseclk_divlock.sv
module tb_baseclk_divlock;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int WIN = 360;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_tick = 1'b1;
  logic osc_tick;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic cpu_en, pbus_en;

  int phase = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int    exp_q[$];
  int    act_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  baseclk_divlock #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .osc_tick(osc_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cpu_en(cpu_en), .pbus_en(pbus_en)
  );

  assign osc_tick = (phase == 0);
  always @(negedge clk) phase <= (phase == 2) ? 0 : phase + 1;

  // monitor: pop and compare scoreboard items
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      int e, a; string t;
      e = exp_q.pop_front(); a = act_q.pop_front(); t = tag_q.pop_front();
      n_chk++;
      if (a != e) begin
        n_bad++;
        $display("FAIL %s actual=%0d expected=%0d", t, a, e);
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    v = int'(rd_data);
  endtask

  function automatic logic [DATA_W-1:0] cc(input bit src, input int pb, input int cp);
    return DATA_W'({src, 2'(pb), 2'(cp)});
  endfunction

  // driver: push expected counts, then count pulses over the window
  task automatic window(input int e_cpu, input int e_pbus, input string tag);
    int nc = 0, np = 0;
    exp_q.push_back(e_cpu);  tag_q.push_back({tag, " cpu_en count"});
    exp_q.push_back(e_pbus); tag_q.push_back({tag, " pbus_en count"});
    repeat (24) @(negedge clk);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (cpu_en) nc++;
      if (pbus_en) np++;
    end
    act_q.push_back(nc);
    act_q.push_back(np);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, g;
    int cpu_exp[4] = '{180, 120, 90, 360};
    int pb_exp[4]  = '{180, 120, 90, 90};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(2'd0, v); check(v, 0, "R1 cctl reset");
    rd(2'd1, v); check(v, 0, "R1 prot reset");
    rd(2'd2, v); check(v, 0, "R1 lock reset");
    rd(2'd3, v); check(v, 0, "R10 unused address");
    window(180, 180, "R1 reset ratios");

    for (int c = 0; c < 4; c++) begin
      wr(2'd0, cc(1'b0, c, c));
      rd(2'd0, v); check(v, int'(cc(1'b0, c, c)), "R10 cctl readback");
      window(cpu_exp[c], pb_exp[c], (c == 3) ? "R2 R3 code 11" : "R2 R3 code");
    end

    // R4: oscillator source, tick every 3 cycles
    wr(2'd0, cc(1'b1, 1, 0));
    window(60, 40, "R4 osc source");
    wr(2'd0, cc(1'b0, 1, 0));
    window(180, 120, "R4 pll source");

    // R5: ratio change waits for period end
    wr(2'd0, cc(1'b0, 0, 2));
    repeat (20) @(negedge clk);
    while (!cpu_en) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = cc(1'b0, 0, 3);
    g = 0;
    do begin @(negedge clk); wr_en = 1'b0; g++; end while (!cpu_en);
    check(g, 4, "R5 gap across change");
    g = 0;
    do begin @(negedge clk); g++; end while (!cpu_en);
    check(g, 1, "R5 gap after change");

    // R6: lock write without protect is ignored
    wr(2'd2, 8'h01);
    rd(2'd2, v); check(v, 0, "R6 lock without protect");
    // R7: protect stays set across other writes
    wr(2'd1, 8'h01);
    wr(2'd0, cc(1'b0, 1, 1));
    rd(2'd1, v); check(v, 1, "R7 protect held");
    // lock
    wr(2'd2, 8'h01);
    rd(2'd2, v); check(v, 1, "R9 lock set");
    // R8: frozen configuration
    wr(2'd0, cc(1'b1, 3, 3));
    rd(2'd0, v); check(v, int'(cc(1'b0, 1, 1)), "R8 cctl frozen");
    window(120, 120, "R8 rates frozen");
    // R9: clear attempt fails
    wr(2'd2, 8'h00);
    rd(2'd2, v); check(v, 1, "R9 lock not clearable");
    wr(2'd1, 8'h00);
    rd(2'd1, v); check(v, 0, "R7 protect cleared by write");
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    rd(2'd2, v); check(v, 0, "R9 lock cleared by reset");
    wr(2'd0, cc(1'b0, 2, 2));
    rd(2'd0, v); check(v, int'(cc(1'b0, 2, 2)), "R9 cctl writable after reset");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule